// File: doc/BRIEF.md
# Bit-Serial Bitonic Key Sorter

This block sorts a batch of unsigned keys by moving every key through a bitonic network one bit per clock, most significant bit first. A single start pulse loads all keys in parallel and clears the network. The block then runs on its own for a fixed number of cycles and raises a one-cycle done pulse when the sorted words are ready on its output.

Every compare-and-swap cell in the network handles one bit of each of its two lanes. A cell stays undecided while its two input streams carry equal bits. On the first bit position where they differ it picks the order that puts the larger (or smaller) stream on its first output, and it keeps that routing until the next start. A register per lane sits between steps, so bit j of every key reaches step s on cycle s + j after the run begins. Cells in one step can therefore settle on different cycles, in no fixed order. The key count (a power of two), the key width and the sort direction are parameters.

Top module: `bsort_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0 and `sorted_out` is all zeros.
- R2: `done` is high for exactly one cycle, starting STEPS + KEY_W rising edges after the edge that samples an accepted `start`. STEPS is k(k+1)/2 for NUM_KEYS = 2^k, so the default of 8 keys of 8 bits gives 14 edges.
- R3: With DESCEND = 1, the word in `sorted_out[KEY_W-1:0]` (lane 0) holds the largest key. Each higher lane holds a key no larger than the lane below it. Key lane l is `keys_in[l*KEY_W +: KEY_W]`, and output lane l uses the same slice of `sorted_out`.
- R4: Every input key appears in the output exactly as often as it appears in the input. This includes keys that are all equal and repeated values.
- R5: A `start` that arrives while a sort is in progress is ignored. The running sort keeps its latency and its result.
- R6: After `done`, `sorted_out` holds its value until the next accepted `start`.
- R7: A cell becomes locked in the cycle its two input bits first differ, and it keeps its routing until the next accepted `start`. Keys that differ only in their least significant bit are still ordered correctly.
- R8: With DESCEND = 0, lane 0 holds the smallest key and each higher lane holds a key no smaller than the lane below it.
- R9: A new sort started right after a previous one gives a result that does not depend on the routing locked during the earlier run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that loads keys and begins a sort when idle |
| keys_in | input | NUM_KEYS*KEY_W | Unsorted keys, lane l at bits [l*KEY_W +: KEY_W] |
| sorted_out | output | NUM_KEYS*KEY_W | Sorted keys, lane 0 first |
| done | output | 1 | One-cycle pulse when the sorted words are valid |

## Verification
The hardest condition to reach from the ports is a cell that stays unfixed until the last bit, or never fixes at all, while its neighbours have already locked. The stimulus creates this with keys that share every bit except the least significant one and with sets of identical keys. A second hazard is routing left over from a previous run. Back-to-back sorts with reversed data would give a wrong order if any cell kept its old lock. A second instance with the opposite direction and a smaller size repeats a four-key case.

// File: rtl/bsort_pkg.sv
`timescale 1ns/1ps
package bsort_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic clear;    // load keys, drop all cell locks, zero pipeline
    logic run;      // advance serial streams and let cells decide
    logic capture;  // shift network output bits into result words
  } bsortCtrl_t;
endpackage

// File: rtl/bsort_cell.sv
`timescale 1ns/1ps
// One-bit compare-and-swap cell with a locking routing decision.
module bsort_cell #(
  parameter bit DESC = 1'b1   // 1: larger stream to outA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic inA,
  input  logic inB,
  output logic outA,
  output logic outB
);
  logic fixed;
  logic swapLatch;
  logic swapNow;
  logic swapUse;

  // Default route: a 1 on inA stays on outA when descending, moves when ascending
  assign swapNow = DESC ? ~inA : inA;
  assign swapUse = fixed ? swapLatch : swapNow;
  assign outA    = swapUse ? inB : inA;
  assign outB    = swapUse ? inA : inB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fixed     <= 1'b0;
      swapLatch <= 1'b0;
    end else if (clear) begin
      fixed     <= 1'b0;
      swapLatch <= 1'b0;
    end else if (run && !fixed) begin
      swapLatch <= swapNow;
      if (inA != inB) fixed <= 1'b1;
    end
  end

  // R7: a lock persists with unchanged routing until cleared
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && !clear) |=> (fixed && $stable(swapLatch)));

  // R7: first differing bit while running locks the cell
  a_r7_lock_on_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !fixed && (inA != inB)) |=> fixed);

  // R4: a cell never creates or drops a one
  a_r4_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones({outA, outB}) == $countones({inA, inB})));
endmodule

// File: rtl/bsort_ctrl.sv
`timescale 1ns/1ps
// Cycle-count controller: turns start into clear, then runs a fixed window.
module bsort_ctrl
  import bsort_pkg::*;
#(
  parameter int STEPS = 6,
  parameter int KEY_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output bsortCtrl_t ctl,
  output logic       done
);
  localparam int RUN_LEN = STEPS + KEY_W;
  localparam int CW      = $clog2(RUN_LEN + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          lastCycle;

  assign lastCycle   = (cnt == CW'(RUN_LEN - 1));
  assign ctl.clear   = start && !busy;
  assign ctl.run     = busy;
  assign ctl.capture = busy && (cnt >= CW'(STEPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.clear) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (lastCycle) begin
          busy <= 1'b0;
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: done is a single-cycle pulse that ends a run
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R5: start during a run neither restarts nor stalls the count
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !lastCycle) |=> (busy && (cnt == $past(cnt) + 1'b1)));
endmodule

// File: rtl/bsort_datapath.sv
`timescale 1ns/1ps
// Serial lanes, bitonic network of one-bit cells, result shift registers.
module bsort_datapath
  import bsort_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int KEY_W    = 8,
  parameter int DESCEND  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bsortCtrl_t                ctl,
  input  logic [NUM_KEYS*KEY_W-1:0] keysIn,
  output logic [NUM_KEYS*KEY_W-1:0] sortedOut
);
  localparam int LOG_N = $clog2(NUM_KEYS);
  localparam int STEPS = LOG_N * (LOG_N + 1) / 2;

  logic [KEY_W-1:0] inShift  [NUM_KEYS];
  logic [KEY_W-1:0] outShift [NUM_KEYS];
  logic             pipe     [STEPS][NUM_KEYS];
  logic             stepIn   [STEPS][NUM_KEYS];
  logic             stepOut  [STEPS][NUM_KEYS];

  // Step inputs: first step reads the key MSBs, later steps read the lane registers
  for (genvar gs = 0; gs < STEPS; gs++) begin : g_in
    for (genvar gl = 0; gl < NUM_KEYS; gl++) begin : g_lane
      if (gs == 0) begin : g_first
        assign stepIn[gs][gl] = inShift[gl][KEY_W-1];
      end else begin : g_next
        assign stepIn[gs][gl] = pipe[gs-1][gl];
      end
    end
  end

  // Bitonic network: stage gp merges runs of 2^gp lanes in gp steps
  for (genvar gp = 1; gp <= LOG_N; gp++) begin : g_stage
    for (genvar gr = 0; gr < gp; gr++) begin : g_step
      localparam int STEP = gp * (gp - 1) / 2 + gr;
      localparam int DIST = 1 << (gp - 1 - gr);
      for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_pos
        if ((gi & DIST) == 0) begin : g_cell
          localparam bit CELL_DESC = (DESCEND != 0) ^ (((gi >> gp) & 1) == 1);
          bsort_cell #(.DESC(CELL_DESC)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (ctl.clear),
            .run   (ctl.run),
            .inA   (stepIn[STEP][gi]),
            .inB   (stepIn[STEP][gi+DIST]),
            .outA  (stepOut[STEP][gi]),
            .outB  (stepOut[STEP][gi+DIST])
          );
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_KEYS; l++) begin
        inShift[l]  <= '0;
        outShift[l] <= '0;
        for (int s = 0; s < STEPS; s++) pipe[s][l] <= 1'b0;
      end
    end else if (ctl.clear) begin
      for (int l = 0; l < NUM_KEYS; l++) begin
        inShift[l]  <= keysIn[l*KEY_W +: KEY_W];
        outShift[l] <= '0;
        for (int s = 0; s < STEPS; s++) pipe[s][l] <= 1'b0;
      end
    end else begin
      for (int l = 0; l < NUM_KEYS; l++) begin
        if (ctl.run) begin
          inShift[l] <= {inShift[l][KEY_W-2:0], 1'b0};
          for (int s = 0; s < STEPS; s++) pipe[s][l] <= stepOut[s][l];
        end
        if (ctl.capture) begin
          outShift[l] <= {outShift[l][KEY_W-2:0], pipe[STEPS-1][l]};
        end
      end
    end
  end

  for (genvar gl = 0; gl < NUM_KEYS; gl++) begin : g_out
    assign sortedOut[gl*KEY_W +: KEY_W] = outShift[gl];
  end

  // R6: result words are frozen whenever no sort is running or starting
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctl.clear) |=> $stable(sortedOut));

  // R2: result capture happens only inside a run
  a_r2_capture_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |-> ctl.run);
endmodule

// File: rtl/bsort_top.sv
`timescale 1ns/1ps
// Top: controller plus serial bitonic datapath.
module bsort_top
  import bsort_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int KEY_W    = 8,
  parameter int DESCEND  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_KEYS*KEY_W-1:0] keys_in,
  output logic [NUM_KEYS*KEY_W-1:0] sorted_out,
  output logic                      done
);
  localparam int LOG_N = $clog2(NUM_KEYS);
  localparam int STEPS = LOG_N * (LOG_N + 1) / 2;

  bsortCtrl_t ctl;

  bsort_ctrl #(.STEPS(STEPS), .KEY_W(KEY_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  bsort_datapath #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .DESCEND(DESCEND)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .keysIn    (keys_in),
    .sortedOut (sorted_out)
  );
endmodule

// File: tb/tb_bsort_top.sv
`timescale 1ns/1ps
module tb_bsort_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        startMain, startAsc;
  logic [63:0] mainKeys, mainOut;
  logic [23:0] ascKeys, ascOut;
  logic        doneMain, doneAsc;
  int          checks = 0;
  int          failures = 0;
  int          seed = 12345;

  always #10 clk = ~clk;   // 50 MHz

  bsort_top #(.NUM_KEYS(8), .KEY_W(8), .DESCEND(1)) dut (
    .clk(clk), .rst_n(rst_n), .start(startMain),
    .keys_in(mainKeys), .sorted_out(mainOut), .done(doneMain));

  bsort_top #(.NUM_KEYS(4), .KEY_W(6), .DESCEND(0)) dutAsc (
    .clk(clk), .rst_n(rst_n), .start(startAsc),
    .keys_in(ascKeys), .sorted_out(ascOut), .done(doneAsc));

  task automatic checkEq(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int nextRnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  // Launch on main instance, wait for done, check latency, order, pulse, hold
  task automatic mainSort(input int k[8], input string req);
    int exp[8];
    int cyc;
    int t;
    exp = k;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (exp[j] < exp[j+1]) begin t = exp[j]; exp[j] = exp[j+1]; exp[j+1] = t; end
    @(negedge clk);
    for (int l = 0; l < 8; l++) mainKeys[l*8 +: 8] = k[l][7:0];
    startMain = 1'b1;
    @(negedge clk);
    startMain = 1'b0;
    cyc = 0;
    while (!doneMain && cyc < 200) begin @(negedge clk); cyc++; end
    checkEq("R2 latency", cyc, 14);
    for (int l = 0; l < 8; l++) checkEq(req, int'(mainOut[l*8 +: 8]), exp[l]);
    @(negedge clk);
    checkEq("R2 single pulse", int'(doneMain), 0);
    mainKeys = ~mainKeys;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 8; l++) checkEq("R6 hold", int'(mainOut[l*8 +: 8]), exp[l]);
  endtask

  // R5: second start mid-run must be ignored
  task automatic testStartIgnored();
    int k[8] = '{3, 200, 77, 150, 9, 255, 64, 128};
    int exp[8] = '{255, 200, 150, 128, 77, 64, 9, 3};
    int cyc;
    @(negedge clk);
    for (int l = 0; l < 8; l++) mainKeys[l*8 +: 8] = k[l][7:0];
    startMain = 1'b1;
    @(negedge clk);
    startMain = 1'b0;
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    mainKeys = '0;
    startMain = 1'b1;
    @(negedge clk); cyc++;
    startMain = 1'b0;
    while (!doneMain && cyc < 200) begin @(negedge clk); cyc++; end
    checkEq("R5 latency unchanged", cyc, 14);
    for (int l = 0; l < 8; l++) checkEq("R5 result kept", int'(mainOut[l*8 +: 8]), exp[l]);
  endtask

  // R8: ascending four-key instance, latency 3 steps + 6 bits
  task automatic ascSort(input int k[4], input string req);
    int exp[4];
    int cyc;
    int t;
    exp = k;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (exp[j] > exp[j+1]) begin t = exp[j]; exp[j] = exp[j+1]; exp[j+1] = t; end
    @(negedge clk);
    for (int l = 0; l < 4; l++) ascKeys[l*6 +: 6] = k[l][5:0];
    startAsc = 1'b1;
    @(negedge clk);
    startAsc = 1'b0;
    cyc = 0;
    while (!doneAsc && cyc < 200) begin @(negedge clk); cyc++; end
    checkEq("R2 latency small", cyc, 9);
    for (int l = 0; l < 4; l++) checkEq(req, int'(ascOut[l*6 +: 6]), exp[l]);
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog expired got=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int kEx[8]   = '{11, 52, 57, 58, 0, 0, 0, 0};
    int kEq[8]   = '{99, 99, 99, 99, 99, 99, 99, 99};
    int kDup[8]  = '{5, 200, 5, 17, 200, 17, 5, 0};
    int kLsb[8]  = '{200, 201, 201, 200, 201, 200, 200, 201};
    int kEdge[8] = '{0, 255, 0, 255, 128, 127, 1, 254};
    int kUp[8]   = '{1, 2, 3, 4, 5, 6, 7, 8};
    int kDown[8] = '{8, 7, 6, 5, 4, 3, 2, 1};
    int kRnd[8];
    int a4[4]    = '{11, 52, 57, 58};
    int b4[4]    = '{63, 0, 63, 31};
    rst_n = 1'b0;
    startMain = 1'b0; startAsc = 1'b0;
    mainKeys = '0; ascKeys = '0;
    repeat (3) @(negedge clk);
    checkEq("R1 done in reset", int'(doneMain), 0);
    checkEq("R1 output in reset", int'(mainOut != 64'd0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1 done after reset", int'(doneMain), 0);
    checkEq("R1 output after reset", int'(mainOut != 64'd0), 0);

    mainSort(kEx,   "R3 example order");
    mainSort(kEq,   "R4 all equal");
    mainSort(kDup,  "R4 duplicates");
    mainSort(kLsb,  "R7 lsb-only difference");
    mainSort(kEdge, "R3 extremes");
    // R9: back-to-back opposite orders, stale locks would misroute
    mainSort(kUp,   "R9 ascending input");
    mainSort(kDown, "R9 descending input");
    for (int r = 0; r < 6; r++) begin
      for (int l = 0; l < 8; l++) kRnd[l] = nextRnd();
      mainSort(kRnd, "R3 pseudo-random");
    end
    testStartIgnored();
    ascSort(a4, "R8 ascending example");
    ascSort(b4, "R8 ascending duplicates");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule